// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets an external host reach a small register file over three wires: a serial clock, a framing line and a shared data line. All three lines are oversampled by the system clock, so the block has a single clock domain. A frame starts when the framing line goes high; bits are taken most significant first on each rising serial-clock edge, and the framing line going low again closes the byte and triggers the serial-to-parallel transfer.

The first byte of a transaction is a register address. If the framing line rises again, the next byte is write data for that address and a one-cycle write strobe is issued on the register-file port. If instead the framing line stays low and the host keeps clocking, the block turns the data line around and shifts out the register at that address, then the next one, and so on. A burst that runs off the last address of the region holding the start address continues at the first address of that region. Three regions are decoded: a writable control region (00h..05h), a read-only status region (40h..45h) and a read-only buffer region (80h..AFh). Any other address reads as zero.

The serial clock must rest low between bytes, and its high and low phases must each last at least three system clocks.

Top module: `tw_regif`

## Requirements
- R1: While reset is asserted and after it is released, the data-line enable and the write strobe are low.
- R2: An address byte followed by a data byte, each framed by the load line high and closed by its falling edge, produces exactly one single-cycle write strobe with the register address equal to the first byte and the write data equal to the second, both taken MSB first on rising serial-clock edges.
- R3: A byte closed with a bit count other than eight is discarded and the transaction restarts, so no write strobe follows; the next correctly formed transaction works normally.
- R4: Only addresses 00h..05h are written; a complete write transaction to a status, buffer or unmapped address produces no write strobe.
- R5: After an address byte, with the load line held low, the block drives the register value at that address onto the data line, MSB first, with each new bit appearing after a falling serial-clock edge so it is stable at the next rising edge.
- R6: Each further group of eight serial clocks in the same read returns the register at the next higher address.
- R7: A read burst wraps at the last address of the region holding the current address to that region's first address: 05h to 00h, 45h to 40h, AFh to 80h.
- R8: A read from an address outside the three regions drives the value 00h.
- R9: The data line is driven only between the close of an address byte and the next rise of the load line; it is undriven while write bytes are shifted and after the load line rises.
- R10: After at least one read bit has been clocked, a rise of the load line starts a new address byte rather than a write data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_load | input | 1 | Framing/load line from the host |
| ser_din | input | 1 | Data line as seen at the pad input |
| ser_dout | output | 1 | Data driven onto the line during reads |
| ser_doe | output | 1 | Output enable for the data-line pad |
| reg_addr | output | AW (8) | Register-file address |
| reg_wdata | output | DW (8) | Register-file write data |
| reg_we | output | 1 | Single-cycle register-file write strobe |
| reg_rdata | input | DW (8) | Register-file read data for reg_addr (combinational) |

## Verification
The bench drives read bursts that start one address before each region's end, since a design that simply incremented would fetch 06h, 46h or B0h instead of wrapping to 00h, 40h or 80h. It sends bytes of seven bits, which a design that did not check the bit count would take as valid and turn into a stray write. It writes to status, buffer and unmapped addresses, where a decoder that only tested "mapped" would corrupt read-only registers, and it reads an unmapped address, where a design passing the register file through would leak nonzero data. It also raises the load line after a read and sends a fresh address and data pair; a design that treated that byte as write data would store the wrong value at the burst's last address.

// File: rtl/tw_regif_pkg.sv
package tw_regif_pkg;

   // transaction phase of the serial slave
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,   // waiting for a framed address byte
      PH_ADDR  = 2'd1,   // shifting the address byte in
      PH_HOLD  = 2'd2,   // address taken; read data driven while load stays low
      PH_WDATA = 2'd3    // shifting the write data byte in
   } phase_t;

   localparam int NUM_REGIONS = 3;

endpackage

// File: rtl/tw_regif_sync.sv
module tw_regif_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_regif_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("tw_regif_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d_in};
   end

   assign d_out = stg[STAGES-1];

endmodule

// File: rtl/tw_regif_map.sv
module tw_regif_map
   import tw_regif_pkg::*;
#(
   parameter int            AW        = 8,
   parameter logic [AW-1:0] CMD_BASE  = 8'h00,
   parameter int            CMD_COUNT = 6,
   parameter logic [AW-1:0] STS_BASE  = 8'h40,
   parameter int            STS_COUNT = 6,
   parameter logic [AW-1:0] BUF_BASE  = 8'h80,
   parameter int            BUF_COUNT = 48
) (
   input  logic [AW-1:0] addr,
   output logic          mapped,
   output logic          writable,
   output logic [AW-1:0] next_addr
);

   localparam logic [AW-1:0] BASE [NUM_REGIONS] = '{CMD_BASE, STS_BASE, BUF_BASE};
   localparam int            CNT  [NUM_REGIONS] = '{CMD_COUNT, STS_COUNT, BUF_COUNT};

   logic [NUM_REGIONS-1:0] hit;
   logic [NUM_REGIONS-1:0] at_end;

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      if (CNT[r] < 1 || CNT[r] >= 2**AW || int'(BASE[r]) + CNT[r] > 2**AW) begin : g_bad
         $error("tw_regif_map: region %0d does not fit the address space", r);
      end
      logic [AW-1:0] off;
      assign off       = addr - BASE[r];
      assign hit[r]    = off < AW'(CNT[r]);
      assign at_end[r] = off == AW'(CNT[r] - 1);
   end

   if (int'(CMD_BASE) + CMD_COUNT > int'(STS_BASE) ||
       int'(STS_BASE) + STS_COUNT > int'(BUF_BASE)) begin : g_bad_order
      $error("tw_regif_map: regions must be ascending and disjoint");
   end

   always_comb begin
      next_addr = addr + AW'(1);
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (hit[r] && at_end[r]) next_addr = BASE[r];
      end
   end

   assign mapped   = |hit;
   assign writable = hit[0];

endmodule

// File: rtl/tw_regif.sv
module tw_regif
   import tw_regif_pkg::*;
#(
   parameter int            AW          = 8,
   parameter int            DW          = 8,
   parameter int            SYNC_STAGES = 2,
   parameter logic [AW-1:0] CMD_BASE    = 8'h00,
   parameter int            CMD_COUNT   = 6,
   parameter logic [AW-1:0] STS_BASE    = 8'h40,
   parameter int            STS_COUNT   = 6,
   parameter logic [AW-1:0] BUF_BASE    = 8'h80,
   parameter int            BUF_COUNT   = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ser_clk,
   input  logic          ser_load,
   input  logic          ser_din,
   output logic          ser_dout,
   output logic          ser_doe,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   output logic          reg_we,
   input  logic [DW-1:0] reg_rdata
);

   localparam int SW = (AW > DW) ? AW : DW;
   localparam int CW = $clog2(SW + 2);
   localparam logic [CW-1:0] CNT_SAT = CW'(SW + 1);

   if (AW < 2 || DW < 2) begin : g_bad_width
      $error("tw_regif: AW and DW must be at least 2");
   end

   // synchronised serial lines and their previous values
   logic [2:0] raw_in, sync_out;
   logic       cl_s, ld_s, da_s;
   logic       cl_q, ld_q;

   assign raw_in = {ser_clk, ser_load, ser_din};

   tw_regif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .d_out (sync_out)
   );

   assign {cl_s, ld_s, da_s} = sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cl_q <= 1'b0;
         ld_q <= 1'b0;
      end else begin
         cl_q <= cl_s;
         ld_q <= ld_s;
      end
   end

   logic cl_rise, cl_fall, ld_rise, ld_fall;
   assign cl_rise = cl_s & ~cl_q;
   assign cl_fall = ~cl_s & cl_q;
   assign ld_rise = ld_s & ~ld_q;
   assign ld_fall = ~ld_s & ld_q;

   // transaction state
   phase_t        phase;
   logic [SW-1:0] sh_in;
   logic [DW-1:0] sh_out;
   logic [CW-1:0] bits;
   logic [AW-1:0] ptr;
   logic          reload;
   logic          rd_started;
   logic          mapped, writable;
   logic [AW-1:0] next_addr;

   tw_regif_map #(
      .AW(AW), .CMD_BASE(CMD_BASE), .CMD_COUNT(CMD_COUNT),
      .STS_BASE(STS_BASE), .STS_COUNT(STS_COUNT),
      .BUF_BASE(BUF_BASE), .BUF_COUNT(BUF_COUNT)
   ) u_map (
      .addr      (ptr),
      .mapped    (mapped),
      .writable  (writable),
      .next_addr (next_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         sh_in      <= '0;
         sh_out     <= '0;
         bits       <= '0;
         ptr        <= '0;
         reload     <= 1'b0;
         rd_started <= 1'b0;
         reg_we     <= 1'b0;
         reg_wdata  <= '0;
      end else begin
         reg_we <= 1'b0;
         reload <= 1'b0;
         if (reload) sh_out <= mapped ? reg_rdata : '0;

         unique case (phase)
            PH_IDLE: begin
               if (ld_rise) begin
                  phase <= PH_ADDR;
                  bits  <= '0;
               end
            end

            PH_ADDR: begin
               if (ld_fall) begin
                  if (bits == CW'(AW)) begin
                     ptr        <= sh_in[AW-1:0];
                     phase      <= PH_HOLD;
                     reload     <= 1'b1;
                     rd_started <= 1'b0;
                     bits       <= '0;
                  end else begin
                     phase <= PH_IDLE;
                  end
               end else if (cl_rise) begin
                  sh_in <= {sh_in[SW-2:0], da_s};
                  if (bits != CNT_SAT) bits <= bits + CW'(1);
               end
            end

            PH_HOLD: begin
               if (ld_rise) begin
                  phase <= rd_started ? PH_ADDR : PH_WDATA;
                  bits  <= '0;
               end else if (cl_rise) begin
                  rd_started <= 1'b1;
                  if (bits != CNT_SAT) bits <= bits + CW'(1);
               end else if (cl_fall && rd_started) begin
                  if (bits == CW'(DW)) begin
                     ptr    <= next_addr;
                     reload <= 1'b1;
                     bits   <= '0;
                  end else begin
                     sh_out <= {sh_out[DW-2:0], 1'b0};
                  end
               end
            end

            PH_WDATA: begin
               if (ld_fall) begin
                  if (bits == CW'(DW) && writable) begin
                     reg_we    <= 1'b1;
                     reg_wdata <= sh_in[DW-1:0];
                  end
                  phase <= PH_IDLE;
               end else if (cl_rise) begin
                  sh_in <= {sh_in[SW-2:0], da_s};
                  if (bits != CNT_SAT) bits <= bits + CW'(1);
               end
            end

            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign ser_doe  = (phase == PH_HOLD);
   assign ser_dout = ser_doe & sh_out[DW-1];
   assign reg_addr = ptr;

endmodule

// File: rtl/tw_regif_chk.sv
module tw_regif_chk #(
   parameter int            AW        = 8,
   parameter logic [AW-1:0] CMD_BASE  = 8'h00,
   parameter int            CMD_COUNT = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ser_doe,
   input logic          ser_dout,
   input logic          reg_we,
   input logic [AW-1:0] reg_addr,
   input logic          cl_s,
   input logic          cl_q,
   input logic          ld_q
);

   logic [AW-1:0] we_off;
   assign we_off = reg_addr - CMD_BASE;

   // R1: reset holds the pad enable and the strobe low
   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!ser_doe && !reg_we))
      else $error("p_quiet_in_reset_r1");

   // R2: write strobe lasts one cycle
   p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we)
      else $error("p_we_single_r2");

   // R4: strobes only land in the control region
   p_we_cmd_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (we_off < AW'(CMD_COUNT)))
      else $error("p_we_cmd_only_r4");

   // R9: line driven only while the sampled load line is low
   p_doe_ld_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ser_doe |-> !ld_q)
      else $error("p_doe_ld_low_r9");

   // R5: driven bit does not move while the serial clock stays high
   p_dout_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_doe && $past(ser_doe) && cl_s && cl_q && $past(cl_s) && $past(cl_q))
      |-> $stable(ser_dout))
      else $error("p_dout_steady_r5");

endmodule

bind tw_regif tw_regif_chk #(
   .AW(AW), .CMD_BASE(CMD_BASE), .CMD_COUNT(CMD_COUNT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ser_doe  (ser_doe),
   .ser_dout (ser_dout),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .cl_s     (cl_s),
   .cl_q     (cl_q),
   .ld_q     (ld_q)
);

// File: tb/tw_regif_test.sv
module tw_regif_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_load = 1'b0;
   logic       ser_din = 1'b0;
   logic       ser_dout, ser_doe;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_we;

   logic [7:0] mem [256];
   int         we_cnt = 0;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;
   bit         oe_in_write = 1'b0;
   logic [7:0] got [8];
   bit         got_oe [8];

   always #10 clk = ~clk;

   tw_regif uut (
      .clk(clk), .rst_n(rst_n),
      .ser_clk(ser_clk), .ser_load(ser_load), .ser_din(ser_din),
      .ser_dout(ser_dout), .ser_doe(ser_doe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata)
   );

   // register-file model
   assign reg_rdata = mem[reg_addr];
   always @(posedge clk) begin
      if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (6) @(negedge clk);
   endtask

   // framed byte, top n bits MSB first, closed by load falling
   task automatic send_byte(input logic [7:0] b, input int n);
      ser_load = 1'b1;
      half();
      for (int i = 0; i < n; i++) begin
         ser_din = b[7-i];
         half();
         ser_clk = 1'b1;
         half();
         if (ser_doe) oe_in_write = 1'b1;
         ser_clk = 1'b0;
      end
      half();
      ser_load = 1'b0;
      half();
   endtask

   task automatic read_byte(output logic [7:0] b, output bit oe_ok);
      oe_ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
         b[7-i] = ser_dout;
         if (!ser_doe) oe_ok = 1'b0;
         ser_clk = 1'b1;
         half();
         ser_clk = 1'b0;
         half();
      end
   endtask

   task automatic end_read();
      ser_load = 1'b1;
      half();
      check(ser_doe == 1'b0, "R9 enable drops on load rise", ser_doe, 0);
      ser_load = 1'b0;
      half();
   endtask

   task automatic read_seq(input logic [7:0] a, input int n);
      send_byte(a, 8);
      for (int k = 0; k < n; k++) read_byte(got[k], got_oe[k]);
      end_read();
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      send_byte(a, 8);
      send_byte(d, 8);
   endtask

   task automatic t_reset();
      check(ser_doe == 1'b0, "R1 doe after reset", ser_doe, 0);
      check(reg_we == 1'b0 && we_cnt == 0, "R1 no strobe after reset", we_cnt, 0);
   endtask

   task automatic t_write();
      int c0 = we_cnt;
      write_reg(8'h03, 8'h3C);
      check(we_cnt == c0 + 1, "R2 one strobe", we_cnt - c0, 1);
      check(mem[3] == 8'h3C, "R2 data stored", mem[3], 8'h3C);
      write_reg(8'h00, 8'hC3);
      check(mem[0] == 8'hC3, "R2 data stored at 00", mem[0], 8'hC3);
      check(oe_in_write == 1'b0, "R9 undriven during write bytes", oe_in_write, 0);
      read_seq(8'h03, 1);
      check(got[0] == 8'h3C, "R5 read back", got[0], 8'h3C);
      check(got_oe[0], "R9 driven during read", got_oe[0], 1);
   endtask

   task automatic t_cmd_wrap();
      write_reg(8'h04, 8'h11);
      write_reg(8'h05, 8'h22);
      read_seq(8'h04, 4);
      check(got[0] == 8'h11, "R5 first burst byte", got[0], 8'h11);
      check(got[1] == 8'h22, "R6 increment", got[1], 8'h22);
      check(got[2] == mem[0], "R7 wrap 05 to 00", got[2], mem[0]);
      check(got[3] == mem[1], "R7 after wrap", got[3], mem[1]);
   endtask

   task automatic t_sts_wrap();
      read_seq(8'h44, 3);
      check(got[0] == mem[8'h44], "R6 status 44", got[0], mem[8'h44]);
      check(got[1] == mem[8'h45], "R6 status 45", got[1], mem[8'h45]);
      check(got[2] == mem[8'h40], "R7 wrap 45 to 40", got[2], mem[8'h40]);
   endtask

   task automatic t_buf_wrap();
      read_seq(8'hAE, 3);
      check(got[1] == mem[8'hAF], "R6 buffer AF", got[1], mem[8'hAF]);
      check(got[2] == mem[8'h80], "R7 wrap AF to 80", got[2], mem[8'h80]);
   endtask

   task automatic t_ro_write();
      int c0 = we_cnt;
      logic [7:0] old41 = mem[8'h41];
      write_reg(8'h41, 8'h77);
      write_reg(8'h90, 8'h77);
      write_reg(8'h20, 8'h77);
      check(we_cnt == c0, "R4 no strobe outside control region", we_cnt - c0, 0);
      read_seq(8'h41, 1);
      check(got[0] == old41, "R4 status unchanged", got[0], old41);
   endtask

   task automatic t_unmapped();
      read_seq(8'h10, 2);
      check(got[0] == 8'h00 && got[1] == 8'h00, "R8 unmapped reads zero",
            {got[0], got[1]}, 0);
      check(got_oe[0], "R8 unmapped still driven", got_oe[0], 1);
   endtask

   task automatic t_short();
      int c0 = we_cnt;
      logic [7:0] old1 = mem[1];
      send_byte(8'h02, 7);
      write_reg(8'h02, 8'h5A);
      check(mem[2] == 8'h5A, "R3 recovers after short address", mem[2], 8'h5A);
      send_byte(8'h01, 8);
      send_byte(8'hFF, 7);
      check(we_cnt == c0 + 1, "R3 short data byte discarded", we_cnt - c0, 1);
      read_seq(8'h01, 1);
      check(got[0] == old1, "R3 target unchanged", got[0], old1);
   endtask

   task automatic t_new_txn();
      logic [7:0] old5 = mem[5];
      logic [7:0] b;
      bit         ok;
      send_byte(8'h04, 8);
      read_byte(b, ok);
      send_byte(8'h02, 8);
      send_byte(8'h6B, 8);
      check(mem[2] == 8'h6B, "R10 new address after read", mem[2], 8'h6B);
      check(mem[5] == old5, "R10 burst target untouched", mem[5], old5);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write();
      t_cmd_wrap();
      t_sts_wrap();
      t_buf_wrap();
      t_ro_write();
      t_unmapped();
      t_short();
      t_new_txn();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule